// File: doc/BRIEF.md
# Streaming Radix-2 FFT Pipeline

This block computes an N-point complex FFT on a continuous stream of samples. Samples enter in natural index order, one per accepted transfer, and transformed bins leave one per transfer in bit-reversed index order. Internally the transform is a chain of log2(N) identical cells. Each cell holds one delay line of N/2^s entries, one butterfly and a two-way switch, and works in decimation-in-frequency order. During the first half of its local period a cell fills the delay line with new samples while it forwards the twiddled differences stored there during the previous period. During the second half it combines each delayed sample with the arriving one. The sum goes forward and the rotated difference goes back into the delay line.

Each cell halves its results, so the binary point moves by one place per cell and the output equals the DFT divided by N. A rotated difference that exceeds the signed range is clipped to the nearest limit. The data path is signed fixed point of width W, and twiddles use TW bits with unity at 2^(TW-2).

Both stream edges use valid/ready. The pipeline moves only when an input sample is accepted, which requires `in_valid` and `in_ready` to be high together. `in_ready` is high whenever the output register is empty or is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds still and no input is taken. Because nothing moves without input, the tail of a frame leaves only when later samples are pushed, such as the next frame or a frame of zeros. Frames follow one another with no gap.

Top module: `fft_stream`

## Requirements
- R1: After reset `out_valid` and `out_last` are low and `in_ready` is high.
- R2: Output position p (0..N-1) of each frame carries DFT bin bitrev(p) of that input frame divided by N, using the kernel e^(-j2πkn/N), within ±6 LSB per component.
- R3: The first `out_valid` appears only after exactly N+log2(N)-1 input samples have been accepted since reset.
- R4: Once primed, with `in_valid` and `out_ready` held high, a valid output is presented on every cycle, so frames stream with no gap.
- R5: `out_last` is high exactly on output position N-1 of each frame, which is every Nth output transfer.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_re`, `out_im` and `out_last` hold their values.
- R7: With no input accepted, `out_valid` never rises, and it falls once the held output is taken.
- R8: A rotated butterfly difference whose component exceeds the W-bit signed range is clipped to the limit of the same sign and never wraps. For example, an input pair ±(120000 + j120000) at indices 2 and N/2+2 with N = 16 gives odd bins of magnitude 131071/8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample can be taken this cycle |
| in_re | input | W | Input real part, signed |
| in_im | input | W | Input imaginary part, signed |
| out_valid | output | 1 | Output bin present |
| out_ready | input | 1 | Consumer takes the output bin |
| out_re | output | W | Output real part, signed, scaled by 1/N |
| out_im | output | W | Output imaginary part, signed, scaled by 1/N |
| out_last | output | 1 | Marks the last bin of a frame |

## Verification
The assertions watch the handshake on every cycle. They check that a stalled output holds its value and blocks input, that `out_valid` never rises without an accepted input, that no output shows up before the priming count is reached, and that `out_last` falls on every Nth transfer. The numerical result cannot be judged cycle by cycle at the ports, so only the bench scenarios show it. These cover an impulse, a DC level, a single tone, an offset imaginary impulse and a frame that drives one rotation into clipping. The bench also shows the exact priming latency and the gap-free flow of back-to-back frames under a steady handshake.

// File: rtl/fft_pkg.sv
package fft_pkg;

  typedef enum logic {PH_FILL = 1'b0, PH_CALC = 1'b1} phase_e;

  localparam real PI_R = 3.14159265358979323846;

  function automatic real taylor_cos(input real x);
    real term;
    real acc;
    term = 1.0;
    acc  = 1.0;
    for (int i = 1; i < 24; i++) begin
      term = -term * x * x / ((2.0 * i - 1.0) * (2.0 * i));
      acc  = acc + term;
    end
    return acc;
  endfunction

  function automatic real taylor_sin(input real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int i = 1; i < 24; i++) begin
      term = -term * x * x / ((2.0 * i) * (2.0 * i + 1.0));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Quantised component of exp(-j*2*pi*e/n), unity at 2^(tw-2)
  function automatic int twiddle_q(input int n, input int e, input bit imag, input int tw);
    real sc;
    real th;
    real v;
    sc = 1.0;
    for (int i = 0; i < tw - 2; i++) sc = sc * 2.0;
    th = 2.0 * PI_R * e / n;
    v  = imag ? -taylor_sin(th) : taylor_cos(th);
    v  = v * sc;
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom #(
  parameter int N     = 16,
  parameter int STAGE = 1,
  parameter int TW    = 18,
  localparam int D    = N >> STAGE,
  localparam int AW   = (D > 1) ? $clog2(D) : 1
) (
  input  logic [AW-1:0]        addr,
  output logic signed [TW-1:0] tw_re,
  output logic signed [TW-1:0] tw_im
);
  localparam int ENT = 1 << AW;

  logic signed [TW-1:0] tab_re [ENT];
  logic signed [TW-1:0] tab_im [ENT];

  for (genvar e = 0; e < ENT; e++) begin : g_ent
    localparam int EXPO = (e % D) << (STAGE - 1);
    localparam logic signed [TW-1:0] C_RE = TW'(fft_pkg::twiddle_q(N, EXPO, 1'b0, TW));
    localparam logic signed [TW-1:0] C_IM = TW'(fft_pkg::twiddle_q(N, EXPO, 1'b1, TW));
    assign tab_re[e] = C_RE;
    assign tab_im[e] = C_IM;
  end

  assign tw_re = tab_re[addr];
  assign tw_im = tab_im[addr];
endmodule

// File: rtl/fft_bfly.sv
module fft_bfly #(
  parameter int W  = 18,
  parameter int TW = 18
) (
  input  logic signed [W-1:0]  a_re,
  input  logic signed [W-1:0]  a_im,
  input  logic signed [W-1:0]  b_re,
  input  logic signed [W-1:0]  b_im,
  input  logic signed [TW-1:0] tw_re,
  input  logic signed [TW-1:0] tw_im,
  output logic signed [W-1:0]  s_re,
  output logic signed [W-1:0]  s_im,
  output logic signed [W-1:0]  d_re,
  output logic signed [W-1:0]  d_im
);
  localparam int PW = W + TW + 2;
  localparam logic signed [PW-1:0] HI = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] LO = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] clip(input logic signed [PW-1:0] v);
    if (v > HI)      return W'(HI);
    else if (v < LO) return W'(LO);
    else             return W'(v);
  endfunction

  logic signed [W:0]    sr, si, dr, di;
  logic signed [PW-1:0] pr, pi;

  assign sr = {a_re[W-1], a_re} + {b_re[W-1], b_re};
  assign si = {a_im[W-1], a_im} + {b_im[W-1], b_im};
  assign dr = {a_re[W-1], a_re} - {b_re[W-1], b_re};
  assign di = {a_im[W-1], a_im} - {b_im[W-1], b_im};

  // halve the sum: one more integer bit per cell
  assign s_re = W'(sr >>> 1);
  assign s_im = W'(si >>> 1);

  // rotate the difference; the extra bit of shift halves it
  assign pr = PW'(dr) * PW'(tw_re) - PW'(di) * PW'(tw_im);
  assign pi = PW'(dr) * PW'(tw_im) + PW'(di) * PW'(tw_re);

  assign d_re = clip(pr >>> (TW - 1));
  assign d_im = clip(pi >>> (TW - 1));
endmodule

// File: rtl/fft_stage.sv
module fft_stage #(
  parameter int N      = 16,
  parameter int STAGE  = 1,
  parameter int W      = 18,
  parameter int TW     = 18,
  parameter int OFFSET = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  output logic signed [W-1:0] out_re,
  output logic signed [W-1:0] out_im
);
  import fft_pkg::*;

  localparam int D        = N >> STAGE;
  localparam int CW       = $clog2(2 * D);
  localparam int AW       = (D > 1) ? $clog2(D) : 1;
  localparam int CNT_INIT = (2 * D - (OFFSET % (2 * D))) % (2 * D);

  logic [CW-1:0]       cnt;
  phase_e              ph;
  logic signed [W-1:0] dl_re [D];
  logic signed [W-1:0] dl_im [D];
  logic signed [W-1:0] head_re, head_im;
  logic signed [W-1:0] push_re, push_im;
  logic signed [W-1:0] nxt_re, nxt_im;
  logic signed [W-1:0] s_re, s_im, d_re, d_im;
  logic signed [TW-1:0] w_re, w_im;

  assign ph      = phase_e'(cnt[CW-1]);
  assign head_re = dl_re[D-1];
  assign head_im = dl_im[D-1];

  fft_twiddle_rom #(.N(N), .STAGE(STAGE), .TW(TW)) u_rom (
    .addr  (cnt[AW-1:0]),
    .tw_re (w_re),
    .tw_im (w_im)
  );

  fft_bfly #(.W(W), .TW(TW)) u_bf (
    .a_re (head_re), .a_im (head_im),
    .b_re (in_re),   .b_im (in_im),
    .tw_re(w_re),    .tw_im(w_im),
    .s_re (s_re),    .s_im (s_im),
    .d_re (d_re),    .d_im (d_im)
  );

  // switch: fill the line and forward stored differences, or combine
  always_comb begin
    if (ph == PH_FILL) begin
      push_re = in_re;
      push_im = in_im;
      nxt_re  = head_re;
      nxt_im  = head_im;
    end else begin
      push_re = d_re;
      push_im = d_im;
      nxt_re  = s_re;
      nxt_im  = s_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= CW'(CNT_INIT);
      out_re <= '0;
      out_im <= '0;
      for (int i = 0; i < D; i++) begin
        dl_re[i] <= '0;
        dl_im[i] <= '0;
      end
    end else if (en) begin
      cnt      <= cnt + CW'(1);
      out_re   <= nxt_re;
      out_im   <= nxt_im;
      dl_re[0] <= push_re;
      dl_im[0] <= push_im;
      for (int i = 1; i < D; i++) begin
        dl_re[i] <= dl_re[i-1];
        dl_im[i] <= dl_im[i-1];
      end
    end
  end
endmodule

// File: rtl/fft_stream.sv
module fft_stream #(
  parameter int N  = 16,
  parameter int W  = 18,
  parameter int TW = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_re,
  output logic signed [W-1:0] out_im,
  output logic                out_last
);
  localparam int STAGES = $clog2(N);
  localparam int LAT    = N + STAGES - 1;
  localparam int PW     = $clog2(LAT + 1);
  localparam int IW     = STAGES;

  logic          en;
  logic [PW-1:0] prime_cnt;
  logic [IW-1:0] out_idx;

  logic signed [W-1:0] ch_re [STAGES+1];
  logic signed [W-1:0] ch_im [STAGES+1];

  assign in_ready = !out_valid || out_ready;
  assign en       = in_valid && in_ready;
  assign ch_re[0] = in_re;
  assign ch_im[0] = in_im;

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    localparam int OFF = (N - (N >> (s - 1))) + (s - 1);
    fft_stage #(.N(N), .STAGE(s), .W(W), .TW(TW), .OFFSET(OFF)) u_st (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .in_re  (ch_re[s-1]),
      .in_im  (ch_im[s-1]),
      .out_re (ch_re[s]),
      .out_im (ch_im[s])
    );
  end

  assign out_re   = ch_re[STAGES];
  assign out_im   = ch_im[STAGES];
  assign out_last = out_valid && (out_idx == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_cnt <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
    end else if (en) begin
      if (prime_cnt != PW'(LAT)) prime_cnt <= prime_cnt + PW'(1);
      out_valid <= (prime_cnt >= PW'(LAT - 1));
      if (prime_cnt == PW'(LAT - 1))  out_idx <= '0;
      else if (prime_cnt == PW'(LAT)) out_idx <= out_idx + IW'(1);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fft_stream_chk.sv
module fft_stream_chk #(
  parameter int N = 16,
  parameter int W = 18
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic signed [W-1:0] out_re,
  input logic signed [W-1:0] out_im,
  input logic                out_last
);
  localparam int LOGN = $clog2(N);
  localparam int LAT  = N + LOGN - 1;
  localparam int AW   = $clog2(LAT + 1);

  logic [AW-1:0]   acc_cnt;
  logic [LOGN-1:0] hs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      hs_cnt  <= '0;
    end else begin
      if (in_valid && in_ready && acc_cnt != AW'(LAT)) acc_cnt <= acc_cnt + AW'(1);
      if (out_valid && out_ready) hs_cnt <= hs_cnt + LOGN'(1);
    end
  end

  AST_PRIME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> acc_cnt >= AW'(LAT)); // R3

  AST_LAST_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (hs_cnt == '1))); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last)); // R6

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R6

  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !(in_valid && in_ready) |=> !out_valid); // R7
endmodule

bind fft_stream fft_stream_chk #(.N(N), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_re    (out_re),
  .out_im    (out_im),
  .out_last  (out_last)
);

// File: tb/sim_fft_stream.sv
module sim_fft_stream;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 16;
  localparam int H    = N / 2;
  localparam int LOGN = 4;
  localparam int W    = 18;
  localparam int TW   = 18;
  localparam int LAT  = N + LOGN - 1;
  localparam int NFR  = 7;
  localparam real TOL = 6.0;
  localparam real PI_B = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [W-1:0] in_re = '0;
  logic signed [W-1:0] in_im = '0;
  logic in_ready, out_valid, out_last;
  logic signed [W-1:0] out_re, out_im;

  always #(CLK_PERIOD/2) clk = ~clk;

  fft_stream #(.N(N), .W(W), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_last(out_last)
  );

  int total = 0;
  int bad = 0;
  int src_re[$];
  int src_im[$];
  real exp_re[$];
  real exp_im[$];
  int acc_in = 0;
  int acc_out = 0;
  bit seen_first = 0;
  bit o_v, o_l, o_ir;
  int o_re, o_im;

  function automatic void chk(input bit ok, input string req, input string what,
                              input real act, input real expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, expv);
    end
  endfunction

  function automatic int bitrev(input int p);
    int r = 0;
    for (int i = 0; i < LOGN; i++) if (p[i]) r |= 1 << (LOGN - 1 - i);
    return r;
  endfunction

  function automatic real clipr(input real v);
    real hi = 131071.0;
    real lo = -131072.0;
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  // expected bins of frame f: even bins from the plain DFT, odd bins from
  // clipped rotated half-differences followed by an N/2-point DFT
  task automatic add_expect(input int f);
    real xr[N], xi[N], br[N], bi[N];
    real yr[H], yi[H];
    for (int n = 0; n < N; n++) begin
      xr[n] = src_re[f*N + n];
      xi[n] = src_im[f*N + n];
    end
    for (int k = 0; k < H; k++) begin
      real dr = (xr[k] - xr[k+H]) / 2.0;
      real di = (xi[k] - xi[k+H]) / 2.0;
      real c = $cos(2.0*PI_B*k/N);
      real s = -$sin(2.0*PI_B*k/N);
      yr[k] = clipr(dr*c - di*s);
      yi[k] = clipr(dr*s + di*c);
    end
    for (int b = 0; b < N; b += 2) begin
      br[b] = 0.0; bi[b] = 0.0;
      for (int n = 0; n < N; n++) begin
        real c = $cos(2.0*PI_B*b*n/N);
        real s = -$sin(2.0*PI_B*b*n/N);
        br[b] += xr[n]*c - xi[n]*s;
        bi[b] += xr[n]*s + xi[n]*c;
      end
      br[b] /= N; bi[b] /= N;
    end
    for (int m = 0; m < H; m++) begin
      br[2*m+1] = 0.0; bi[2*m+1] = 0.0;
      for (int k = 0; k < H; k++) begin
        real c = $cos(2.0*PI_B*m*k/H);
        real s = -$sin(2.0*PI_B*m*k/H);
        br[2*m+1] += yr[k]*c - yi[k]*s;
        bi[2*m+1] += yr[k]*s + yi[k]*c;
      end
      br[2*m+1] /= H; bi[2*m+1] /= H;
    end
    for (int p = 0; p < N; p++) begin
      exp_re.push_back(br[bitrev(p)]);
      exp_im.push_back(bi[bitrev(p)]);
    end
  endtask

  task automatic put(input int re, input int im);
    src_re.push_back(re);
    src_im.push_back(im);
  endtask

  // one cycle: drive after the falling edge, observe before the rising edge
  task automatic step(input bit iv, input bit ordy);
    @(negedge clk);
    out_ready = ordy;
    in_valid  = iv && (acc_in < src_re.size());
    if (in_valid) begin
      in_re = W'(src_re[acc_in]);
      in_im = W'(src_im[acc_in]);
    end
    #1;
    o_v = out_valid; o_l = out_last; o_ir = in_ready;
    o_re = out_re; o_im = out_im;
    if (out_valid && !seen_first) begin
      seen_first = 1;
      chk(acc_in == LAT, "R3", "accepted samples before first output", acc_in, LAT);
    end
    if (out_valid && out_ready) begin
      int pos = acc_out % N;
      int fr = acc_out / N;
      string rq = (fr == 3) ? "R8" : "R2";
      if (acc_out < exp_re.size()) begin
        chk((o_re - exp_re[acc_out]) <= TOL && (exp_re[acc_out] - o_re) <= TOL,
            rq, $sformatf("re frame %0d pos %0d", fr, pos), o_re, exp_re[acc_out]);
        chk((o_im - exp_im[acc_out]) <= TOL && (exp_im[acc_out] - o_im) <= TOL,
            rq, $sformatf("im frame %0d pos %0d", fr, pos), o_im, exp_im[acc_out]);
      end
      chk(o_l == (pos == N-1), "R5", $sformatf("last flag pos %0d", pos), o_l, (pos == N-1));
      acc_out++;
    end
    if (in_valid && in_ready) acc_in++;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL R4 watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sr0, si0, sb0, sl0;
    // frame 0: real impulse at n=0
    for (int n = 0; n < N; n++) put((n == 0) ? 65536 : 0, 0);
    // frame 1: DC level
    for (int n = 0; n < N; n++) put(40000, -20000);
    // frame 2: complex tone at bin 3
    for (int n = 0; n < N; n++)
      put($rtoi($floor(50000.0*$cos(2.0*PI_B*3*n/N) + 0.5)),
          $rtoi($floor(50000.0*$sin(2.0*PI_B*3*n/N) + 0.5)));
    // frame 3: pair that drives one rotated difference past full scale
    for (int n = 0; n < N; n++)
      put((n == 2) ? 120000 : ((n == H+2) ? -120000 : 0),
          (n == 2) ? 120000 : ((n == H+2) ? -120000 : 0));
    // frame 4: imaginary impulse at n=5
    for (int n = 0; n < N; n++) put(0, (n == 5) ? 30000 : 0);
    // frames 5, 6: zeros to push the tail out
    for (int n = 0; n < 2*N; n++) put(0, 0);
    for (int f = 0; f < NFR; f++) add_expect(f);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(out_last == 1'b0, "R1", "out_last after reset", out_last, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // irregular handshake on both sides over the first three frames
    for (int c = 0; c < 2000 && acc_in < 3*N; c++)
      step(!(c % 7 == 3), !(c % 5 == 2));

    // idle input: output drains and stays empty
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b1);
      if (i >= 1) chk(o_v == 1'b0, "R7", "out_valid with no input", o_v, 0);
    end

    // stalled consumer: output frozen, input blocked
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0);
      if (i == 1) begin
        sr0 = o_re; si0 = o_im; sl0 = o_l; sb0 = o_v;
        chk(o_v == 1'b1, "R6", "out_valid during stall", o_v, 1);
      end
      if (i >= 1) chk(o_ir == 1'b0, "R6", "in_ready during stall", o_ir, 0);
      if (i >= 2) begin
        chk(o_re == sr0 && o_im == si0, "R6", "data held during stall", o_re, sr0);
        chk(o_l == sl0 && o_v == sb0, "R6", "flags held during stall", o_l, sl0);
      end
    end

    // steady flow to the end of the stream
    for (int c = 0; c < 2000 && acc_in < src_re.size(); c++) begin
      step(1'b1, 1'b1);
      chk(o_v == 1'b1, "R4", "output every cycle in steady flow", o_v, 1);
    end
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);

    chk(acc_out >= 5*N, "R2", "bins compared", acc_out, 5*N);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule